// File: doc/BRIEF.md
# Configurable Logic Cell

This block models a single configurable cell of a programmable logic fabric. A 16-entry look-up table, filled from a static configuration mask, computes any function of four data inputs. A programmable storage element can then register that function, or a value it takes from elsewhere. Three output multiplexers each choose, on their own, between the table result and the stored bit. A dedicated arithmetic mode replaces the table function with a one-bit add/subtract slice. That slice produces carry-outs for both carry-in assumptions so a carry-select chain can be built from neighbouring cells.

The storage element can behave as a D, toggle, JK or set/reset flip-flop. It has asynchronous clear and an asynchronous load that either presets it or copies the third data input. It also has synchronous clear and load gated by the clock enable. Its input can come from the table, from the fourth data input, or from the previous cell's register-chain output. The fourth-input option lets the table and the register carry two unrelated functions.

Top module: `logic_cell`

## Requirements
- R1: `cfg_i` layout: bits [24:9] table mask, [8:7] register mode (0 D, 1 toggle, 2 JK, 3 set/reset), bit 6 arithmetic mode, bit 5 register fed from data4, bit 4 register fed from `chain_i`, bit 3 asynchronous load presets to 1, bits [2:0] output select. Outside arithmetic mode the table result is `mask[din_i]` with `din_i[0]` as least significant index bit, and it reaches any output whose select bit is 0 without a clock.
- R2: Output select bit 0 steers `route_a_o`, bit 1 `route_b_o`, bit 2 `local_o`; a 1 picks the register, a 0 the table. `chain_o` always shows the register.
- R3: D mode: on a rising clock with `ce_i` high and no clear or load active, the register takes its source. With `ce_i` low it holds.
- R4: Toggle mode: an enabled clock inverts the register when its source is 1 and holds it when 0.
- R5: JK mode with J = `din_i[0]`, K = `din_i[1]`: 00 hold, 10 set, 01 clear, 11 invert.
- R6: Set/reset mode with S = `din_i[0]`, R = `din_i[1]`: 10 set, 01 clear, 00 and 11 hold.
- R7: `rst_ni` low or `aclr_i` high clears the register at once, over every other control.
- R8: `aload_i` high, with no clear, sets the register at once to 1 when the preset bit is 1, else to `din_i[2]`, and overrides all synchronous controls.
- R9: With `ce_i` high, `sclr_i` clears the register and outranks `sload_i`, which loads `din_i[2]`; both outrank normal capture and do nothing while `ce_i` is low.
- R10: With the data4 source bit set, the register captures `din_i[3]` while the table result still drives the outputs selecting it.
- R11: With the chain source bit set, the register captures `chain_i`, which takes precedence over the data4 source.
- R12: Arithmetic mode: a = `din_i[0]`, b = `din_i[1]` XOR `addsub_i`, carry-in = `cin_sel_i` ? `cin1_i` : `cin0_i`. The table result is a^b^carry-in, `cout0_o` = majority(a,b,`cin0_i`) and `cout1_o` = majority(a,b,`cin1_i`). Both carry-outs are 0 outside arithmetic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the register |
| cfg_i | input | 25 | Static configuration word |
| din_i | input | 4 | Data inputs, bit 0 is data1 |
| ce_i | input | 1 | Clock enable |
| sclr_i | input | 1 | Synchronous clear |
| sload_i | input | 1 | Synchronous load of data3 |
| aclr_i | input | 1 | Asynchronous clear |
| aload_i | input | 1 | Asynchronous load / preset |
| addsub_i | input | 1 | Inverts the second arithmetic operand |
| cin0_i | input | 1 | Carry-in of chain 0 |
| cin1_i | input | 1 | Carry-in of chain 1 |
| cin_sel_i | input | 1 | Selects which carry-in feeds the sum |
| chain_i | input | 1 | Register-chain input from the previous cell |
| route_a_o | output | 1 | First routing output |
| route_b_o | output | 1 | Second routing output |
| local_o | output | 1 | Local routing output |
| cout0_o | output | 1 | Carry-out for carry-in chain 0 |
| cout1_o | output | 1 | Carry-out for carry-in chain 1 |
| chain_o | output | 1 | Register-chain output |

## Verification
The properties assume that asynchronous clear and load change only between clock edges and stay put across at least one edge once raised. They also assume that data3 stays steady while the load is held and that the configuration word changes only between edges. Under those conditions the register value sampled at an edge reflects the controls sampled at the previous one. The stimulus honours this by driving every input, including the configuration word, on the falling clock edge, and by holding each asynchronous pulse for a whole cycle.

// File: rtl/logic_cell_pkg.sv
package logic_cell_pkg;
  localparam int unsigned LUT_K  = 4;
  localparam int unsigned MASK_W = 1 << LUT_K;
  localparam int unsigned N_OUT  = 3;

  typedef enum logic [1:0] {
    FF_D  = 2'd0,
    FF_T  = 2'd1,
    FF_JK = 2'd2,
    FF_SR = 2'd3
  } ff_mode_e;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    ff_mode_e          mode;
    logic              arith;
    logic              pack_src;
    logic              chain_src;
    logic              preset_sel;
    logic [N_OUT-1:0]  out_reg;
  } cell_cfg_t;

  localparam int unsigned CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/lc_lut.sv
module lc_lut #(
  parameter int unsigned K = 4,
  localparam int unsigned W = 1 << K
) (
  input  logic [W-1:0] mask_i,
  input  logic [K-1:0] din_i,
  input  logic         arith_i,
  input  logic         addsub_i,
  input  logic         cin0_i,
  input  logic         cin1_i,
  input  logic         cin_sel_i,
  output logic         lut_o,
  output logic         cout0_o,
  output logic         cout1_o
);
  logic op_a, op_b, cin;

  assign op_a = din_i[0];
  assign op_b = din_i[1] ^ addsub_i;
  assign cin  = cin_sel_i ? cin1_i : cin0_i;

  always_comb begin
    if (arith_i) begin
      lut_o   = op_a ^ op_b ^ cin;
      cout0_o = (op_a & op_b) | (op_a & cin0_i) | (op_b & cin0_i);
      cout1_o = (op_a & op_b) | (op_a & cin1_i) | (op_b & cin1_i);
    end else begin
      lut_o   = mask_i[din_i];
      cout0_o = 1'b0;
      cout1_o = 1'b0;
    end
  end

  // equal carry-ins must give equal carry-outs
  always_comb begin
    if (arith_i && (cin0_i == cin1_i))
      p_cout_match_r12: assert (cout0_o == cout1_o);
  end
endmodule

// File: rtl/lc_ff.sv
module lc_ff
  import logic_cell_pkg::*;
#(
  parameter int unsigned K = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  ff_mode_e     mode_i,
  input  logic         pack_src_i,
  input  logic         chain_src_i,
  input  logic         preset_sel_i,
  input  logic         lut_i,
  input  logic [K-1:0] din_i,
  input  logic         chain_i,
  input  logic         ce_i,
  input  logic         sclr_i,
  input  logic         sload_i,
  input  logic         aclr_i,
  input  logic         aload_i,
  output logic         q_o
);
  logic src, q_next, aload_val;

  assign aload_val = preset_sel_i ? 1'b1 : din_i[2];

  always_comb begin
    if (chain_src_i)     src = chain_i;
    else if (pack_src_i) src = din_i[K-1];
    else                 src = lut_i;
  end

  always_comb begin
    unique case (mode_i)
      FF_D:  q_next = src;
      FF_T:  q_next = q_o ^ src;
      FF_JK: q_next = (din_i[0] & ~q_o) | (~din_i[1] & q_o);
      FF_SR: begin
        if (din_i[0] && !din_i[1])      q_next = 1'b1;
        else if (!din_i[0] && din_i[1]) q_next = 1'b0;
        else                            q_next = q_o;
      end
      default: q_next = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni or posedge aclr_i or posedge aload_i) begin
    if (!rst_ni || aclr_i) q_o <= 1'b0;
    else if (aload_i)      q_o <= aload_val;
    else if (ce_i) begin
      if (sclr_i)          q_o <= 1'b0;
      else if (sload_i)    q_o <= din_i[2];
      else                 q_o <= q_next;
    end
  end

  p_aclr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aclr_i |-> !q_o);

  p_preset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aload_i && preset_sel_i && !aclr_i) |-> q_o);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && !aclr_i && !aload_i) |=> (aclr_i || aload_i || $stable(q_o)));

  p_dcap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FF_D && !chain_src_i && !pack_src_i && ce_i && !sclr_i && !sload_i
     && !aclr_i && !aload_i) |=> (aclr_i || aload_i || q_o == $past(lut_i)));

  p_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FF_T && src && ce_i && !sclr_i && !sload_i && !aclr_i && !aload_i)
    |=> (aclr_i || aload_i || q_o != $past(q_o)));

  p_sr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FF_SR && din_i[0] && din_i[1] && ce_i && !sclr_i && !sload_i
     && !aclr_i && !aload_i) |=> (aclr_i || aload_i || $stable(q_o)));

  p_sclr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && sclr_i && !aclr_i && !aload_i) |=> (aclr_i || aload_i || !q_o));
endmodule

// File: rtl/lc_outsel.sv
module lc_outsel #(
  parameter int unsigned N = 3
) (
  input  logic         lut_i,
  input  logic         q_i,
  input  logic [N-1:0] sel_i,
  output logic [N-1:0] out_o
);
  for (genvar g = 0; g < N; g++) begin : g_out
    assign out_o[g] = sel_i[g] ? q_i : lut_i;
  end
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import logic_cell_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [LUT_K-1:0] din_i,
  input  logic             ce_i,
  input  logic             sclr_i,
  input  logic             sload_i,
  input  logic             aclr_i,
  input  logic             aload_i,
  input  logic             addsub_i,
  input  logic             cin0_i,
  input  logic             cin1_i,
  input  logic             cin_sel_i,
  input  logic             chain_i,
  output logic             route_a_o,
  output logic             route_b_o,
  output logic             local_o,
  output logic             cout0_o,
  output logic             cout1_o,
  output logic             chain_o
);
  cell_cfg_t        cfg;
  logic             lut, q;
  logic [N_OUT-1:0] outs;

  assign cfg = cell_cfg_t'(cfg_i);

  lc_lut #(.K(LUT_K)) i_lut (
    .mask_i    (cfg.mask),
    .din_i     (din_i),
    .arith_i   (cfg.arith),
    .addsub_i  (addsub_i),
    .cin0_i    (cin0_i),
    .cin1_i    (cin1_i),
    .cin_sel_i (cin_sel_i),
    .lut_o     (lut),
    .cout0_o   (cout0_o),
    .cout1_o   (cout1_o)
  );

  lc_ff #(.K(LUT_K)) i_ff (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (cfg.mode),
    .pack_src_i   (cfg.pack_src),
    .chain_src_i  (cfg.chain_src),
    .preset_sel_i (cfg.preset_sel),
    .lut_i        (lut),
    .din_i        (din_i),
    .chain_i      (chain_i),
    .ce_i         (ce_i),
    .sclr_i       (sclr_i),
    .sload_i      (sload_i),
    .aclr_i       (aclr_i),
    .aload_i      (aload_i),
    .q_o          (q)
  );

  lc_outsel #(.N(N_OUT)) i_outsel (
    .lut_i (lut),
    .q_i   (q),
    .sel_i (cfg.out_reg),
    .out_o (outs)
  );

  assign route_a_o = outs[0];
  assign route_b_o = outs[1];
  assign local_o   = outs[2];
  assign chain_o   = q;
endmodule

// File: tb/test_logic_cell.sv
`timescale 1ns/1ps
module test_logic_cell;
  import logic_cell_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CFG_W-1:0] cfg = '0;
  logic [3:0] din = '0;
  logic ce = 0, sclr = 0, sload = 0, aclr = 0, aload = 0;
  logic addsub = 0, cin0 = 0, cin1 = 0, cin_sel = 0, chain_in = 0;
  logic ra, rb, lo, c0, c1, co;

  // staged stimulus, applied by the driver on the falling edge
  logic [24:0] s_cfg = '0;
  logic [3:0]  s_din = '0;
  logic s_rst = 0, s_ce = 0, s_sclr = 0, s_sload = 0, s_aclr = 0, s_aload = 0;
  logic s_as = 0, s_c0 = 0, s_c1 = 0, s_cs = 0, s_ch = 0;
  logic m_q = 0;

  typedef struct { logic [5:0] exp; string req; } item_t;
  item_t sb[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  logic_cell i_logic_cell (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .din_i(din), .ce_i(ce),
    .sclr_i(sclr), .sload_i(sload), .aclr_i(aclr), .aload_i(aload),
    .addsub_i(addsub), .cin0_i(cin0), .cin1_i(cin1), .cin_sel_i(cin_sel),
    .chain_i(chain_in), .route_a_o(ra), .route_b_o(rb), .local_o(lo),
    .cout0_o(c0), .cout1_o(c1), .chain_o(co)
  );

  function automatic logic maj(logic x, logic y, logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic logic m_lut();
    logic a = s_din[0];
    logic b = s_din[1] ^ s_as;
    logic ci = s_cs ? s_c1 : s_c0;
    if (s_cfg[6]) return a ^ b ^ ci;
    return s_cfg[9 + s_din];
  endfunction

  function automatic logic m_next(logic q);
    logic src;
    if (!s_rst || s_aclr) return 1'b0;
    if (s_aload) return s_cfg[3] ? 1'b1 : s_din[2];
    if (!s_ce) return q;
    if (s_sclr) return 1'b0;
    if (s_sload) return s_din[2];
    src = s_cfg[4] ? s_ch : (s_cfg[5] ? s_din[3] : m_lut());
    case (s_cfg[8:7])
      2'd0: return src;
      2'd1: return src ? ~q : q;
      2'd2: case (s_din[1:0])
              2'b01: return 1'b1;
              2'b10: return 1'b0;
              2'b11: return ~q;
              default: return q;
            endcase
      default: case (s_din[1:0])
              2'b01: return 1'b1;
              2'b10: return 1'b0;
              default: return q;
            endcase
    endcase
  endfunction

  // driver: applies staged inputs, updates the model, queues the expectation
  task automatic tick(input string req);
    item_t it;
    logic l, k0, k1;
    @(negedge clk);
    rst_n = s_rst; cfg = s_cfg; din = s_din; ce = s_ce; sclr = s_sclr;
    sload = s_sload; aclr = s_aclr; aload = s_aload; addsub = s_as;
    cin0 = s_c0; cin1 = s_c1; cin_sel = s_cs; chain_in = s_ch;
    m_q = m_next(m_q);
    l  = m_lut();
    k0 = s_cfg[6] & maj(s_din[0], s_din[1] ^ s_as, s_c0);
    k1 = s_cfg[6] & maj(s_din[0], s_din[1] ^ s_as, s_c1);
    it.exp = {s_cfg[0] ? m_q : l, s_cfg[1] ? m_q : l, s_cfg[2] ? m_q : l, k0, k1, m_q};
    it.req = req;
    sb.push_back(it);
  endtask

  // monitor: compares away from the rising edge
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      item_t it;
      logic [5:0] act;
      it = sb.pop_front();
      act = {ra, rb, lo, c0, c1, co};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %b expected %b (ra rb lo c0 c1 chain)", it.req, act, it.exp);
      end
    end
  end

  function automatic logic [24:0] mk(logic [15:0] m, logic [1:0] md, logic ar,
                                     logic pk, logic chs, logic pre, logic [2:0] os);
    return {m, md, ar, pk, chs, pre, os};
  endfunction

  task automatic ctl(logic e, logic sc, logic sl, logic ac, logic al);
    s_ce = e; s_sclr = sc; s_sload = sl; s_aclr = ac; s_aload = al;
  endtask

  initial begin
    // R7: reset state
    s_cfg = mk(16'hFFFF, 2'd0, 0, 0, 0, 0, 3'b111);
    s_din = 4'hF; s_ce = 1;
    tick("R7"); tick("R7");
    s_rst = 1; ctl(0, 0, 0, 0, 0);

    // R1: table function with all outputs on the table, couts zero
    s_cfg = mk(16'h6996, 2'd0, 0, 0, 0, 0, 3'b000);
    for (int i = 0; i < 16; i++) begin s_din = i[3:0]; tick("R1"); end
    s_cfg = mk(16'h8001, 2'd0, 0, 0, 0, 0, 3'b000);
    for (int i = 0; i < 16; i++) begin s_din = i[3:0]; tick("R1"); end

    // R3: D capture with enable, hold without
    s_cfg = mk(16'h00F0, 2'd0, 0, 0, 0, 0, 3'b001);
    ctl(1, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) begin s_din = 4'(i * 5); tick("R3"); end
    s_din = 4'h4; tick("R3");
    ctl(0, 0, 0, 0, 0);
    s_din = 4'h0; tick("R3"); s_din = 4'h9; tick("R3");

    // R2: independent output selects
    s_cfg = mk(16'hFFFF, 2'd0, 0, 0, 0, 0, 3'b000);
    ctl(1, 1, 0, 0, 0); tick("R2");
    ctl(0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      s_cfg = mk(16'hFFFF, 2'd0, 0, 0, 0, 0, i[2:0]); tick("R2");
    end

    // R4: toggle on source 1, hold on 0
    s_cfg = mk(16'hAAAA, 2'd1, 0, 0, 0, 0, 3'b010);
    ctl(1, 0, 0, 0, 0);
    s_din = 4'h1; tick("R4"); tick("R4"); tick("R4");
    s_din = 4'h0; tick("R4"); tick("R4");
    s_din = 4'h3; tick("R4");

    // R5: JK combinations
    s_cfg = mk(16'h0000, 2'd2, 0, 0, 0, 0, 3'b100);
    foreach (s_din[i]) ;
    s_din = 4'h1; tick("R5");
    s_din = 4'h0; tick("R5");
    s_din = 4'h2; tick("R5");
    s_din = 4'h3; tick("R5"); tick("R5");
    s_din = 4'h1; tick("R5");

    // R6: set/reset, both high holds
    s_cfg = mk(16'h0000, 2'd3, 0, 0, 0, 0, 3'b100);
    s_din = 4'h1; tick("R6");
    s_din = 4'h3; tick("R6"); tick("R6");
    s_din = 4'h2; tick("R6");
    s_din = 4'h3; tick("R6");
    s_din = 4'h0; tick("R6");

    // R9: sync clear over sync load, enable gating
    s_cfg = mk(16'h0000, 2'd0, 0, 0, 0, 0, 3'b111);
    s_din = 4'h4;
    ctl(1, 0, 1, 0, 0); tick("R9");
    ctl(1, 1, 1, 0, 0); tick("R9");
    ctl(0, 0, 1, 0, 0); tick("R9");
    ctl(1, 0, 1, 0, 0); tick("R9");
    ctl(0, 1, 0, 0, 0); tick("R9");
    s_din = 4'h0; ctl(1, 0, 1, 0, 0); tick("R9");

    // R7: async clear beats everything
    s_din = 4'h4; ctl(1, 0, 1, 0, 0); tick("R7");
    ctl(1, 0, 1, 1, 1); tick("R7");
    ctl(0, 0, 0, 0, 0); tick("R7");

    // R8: async load, preset and data3 variants
    s_cfg = mk(16'h0000, 2'd0, 0, 0, 0, 1, 3'b111);
    ctl(1, 1, 0, 0, 1); tick("R8");
    ctl(0, 0, 0, 0, 0); tick("R8");
    s_cfg = mk(16'h0000, 2'd0, 0, 0, 0, 0, 3'b111);
    s_din = 4'h0; ctl(1, 0, 0, 0, 1); tick("R8");
    ctl(0, 0, 0, 0, 0); tick("R8");
    s_din = 4'h4; ctl(1, 1, 0, 0, 1); tick("R8");
    ctl(0, 0, 0, 0, 0); s_din = 4'h0; tick("R8");

    // R10: register from data4, table on the other output
    s_cfg = mk(16'h8080, 2'd0, 0, 1, 0, 0, 3'b010);
    ctl(1, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) begin s_din = 4'(i * 7); tick("R10"); end

    // R11: register from chain input, precedence over data4
    s_cfg = mk(16'hFFFF, 2'd0, 0, 1, 1, 0, 3'b001);
    s_din = 4'hF;
    s_ch = 0; tick("R11");
    s_ch = 1; tick("R11");
    s_din = 4'h0; s_ch = 0; tick("R11");
    s_ch = 1; tick("R11");

    // R12: arithmetic slice over every operand combination
    s_cfg = mk(16'h0000, 2'd0, 1, 0, 0, 0, 3'b000);
    s_ch = 0; ctl(0, 0, 0, 0, 0);
    for (int i = 0; i < 64; i++) begin
      s_din = {2'b00, i[1:0]};
      s_c0 = i[2]; s_c1 = i[3]; s_cs = i[4]; s_as = i[5];
      tick("R12");
    end
    s_cfg = mk(16'h0000, 2'd0, 1, 0, 0, 0, 3'b111);
    ctl(1, 0, 0, 0, 0);
    s_din = 4'h1; s_c0 = 1; s_c1 = 0; s_cs = 0; s_as = 0; tick("R12");
    s_cs = 1; tick("R12");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule